// File: doc/BRIEF.md
# Recoverable-Region Fault Redirect Controller

This controller sits beside the commit stage of a simple in-order core. It follows whether the core is executing inside a region of code that software has declared recoverable by re-execution or by substitution. A marker instruction opens the region and carries the address of a software recovery handler. The same marker with a zero operand closes the region. While a region is open, a fault report from an external detector turns into a single-cycle fetch redirect to the handler. The controller takes no checkpoint and does no rollback. Results that have already committed, corrupted or not, stay as they are. Recovery is left entirely to the handler.

Fault reports reach the controller up to `DET_LAT` cycles after the faulty instruction commits. Because of this, the controller still treats faults as recoverable for `DET_LAT` cycles after the region closes. For the same reason it holds back a hardware exception raised inside the region for `DET_LAT` cycles, so that a late fault report can take priority over the trap. If an atomic operation commits inside a region, or a second region is opened while one is already open, the controller signals an illegal-operation error. A fault that no region covers is reported as unrecoverable.

Top module: `rcv_region_ctrl`

## Requirements
- R1: A commit with kind 2'b01 (region marker) and a nonzero operand, made while no region is open, sets `relaxed_mode` from the next cycle and latches the operand as the handler address.
- R2: A region marker with a zero operand, committed while a region is open, clears `relaxed_mode` on the next cycle.
- R3: A fault reported while a region is open produces, one cycle later, `redirect_valid` high for exactly one cycle, with `redirect_pc` equal to the latched handler address. `redirect_pc` reads zero in every other cycle.
- R4: A fault reported in the cycle of the closing marker's commit, or in any of the `DET_LAT` cycles after it, still redirects to the latched handler address. A fault reported one cycle later than that does not redirect.
- R5: A fault reported with no region open and no window from R4 running asserts `unrec_fault` for one cycle, one cycle later, and produces no redirect.
- R6: After a redirect, `relaxed_mode` is low, and a further fault is unrecoverable until a new region is opened.
- R7: When `exc_req` rises while a region is open, `exc_hold` is high during the first `DET_LAT` cycles of the request and low after them. A request made with no region open is never held.
- R8: A fault reported while an exception is being held wins over the trap: the redirect is issued, and `exc_hold` stays high through the redirect cycle.
- R9: An atomic commit (kind 2'b10) inside a region pulses `illegal_err` one cycle later. Outside a region it raises no error, and in neither case does it change `relaxed_mode`.
- R10: A nonzero region marker committed while a region is already open pulses `illegal_err` and leaves the handler address unchanged.
- R11: After reset, `relaxed_mode`, `redirect_valid`, `redirect_pc`, `exc_hold`, `illegal_err` and `unrec_fault` are all zero.
- R12: A closing marker committed while no region is open has no effect: a fault in the next cycle is unrecoverable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_kind | input | 2 | 00 plain, 01 region marker, 10 atomic, 11 treated as plain |
| cmt_operand | input | PC_W | Operand of a region marker (handler address, or zero to close) |
| fault_valid | input | 1 | Fault report from the detector |
| exc_req | input | 1 | Pipeline wants to take a hardware exception |
| redirect_valid | output | 1 | Fetch redirect request, one cycle |
| redirect_pc | output | PC_W | Redirect target, zero when no redirect is requested |
| exc_hold | output | 1 | Exception must not be taken this cycle |
| illegal_err | output | 1 | Illegal operation inside a region, one cycle |
| unrec_fault | output | 1 | Fault with no region to recover it, one cycle |
| relaxed_mode | output | 1 | A recoverable region is open |

## Verification
The checker watches several properties on every cycle:
- every redirect and every unrecoverable report traces back to a fault in the previous cycle;
- a redirect and an unrecoverable report never occur together;
- a redirect always leaves the region closed, with a nonzero target;
- the hold never runs longer than the detection latency;
- an atomic commit or a nested open inside a region always raises the error.

The bench scenarios are needed for the timing claims. They sweep the fault position across the post-exit window and past its end. They sweep the exception hold length, and they sweep the fault position inside the hold. They also cover retry after a redirect and a closing marker outside any region.

// File: rtl/rcv_region_pkg.sv
// Package: shared commit-kind encoding for the region recovery controller.
// Assumes the commit stage presents one classified instruction per cycle.
package rcv_region_pkg;
    typedef enum logic [1:0] {
        CK_PLAIN  = 2'b00,
        CK_MARK   = 2'b01,
        CK_ATOMIC = 2'b10,
        CK_RSVD   = 2'b11
    } cmt_kind_e;
endpackage

// File: rtl/rcv_region_track.sv
// Region tracker: decodes region markers and atomics at commit, holds the
// mode flag, the handler address and the post-exit detection window.
// Assumes flush is the redirect firing this cycle; flush overrides commits.
module rcv_region_track
    import rcv_region_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int DET_LAT = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmt_valid,
    input  logic [1:0]      cmt_kind,
    input  logic [PC_W-1:0] cmt_operand,
    input  logic            flush,
    output logic            relaxed,
    output logic [PC_W-1:0] rpc,
    output logic            covered,
    output logic            illegal_err
);
    localparam int GW = $clog2(DET_LAT + 1);
    localparam logic [GW-1:0] GRACE_INIT = GW'(DET_LAT);

    logic [GW-1:0] grace;
    logic is_mark, is_enter, is_exit, is_atomic;

    // Classify the committing instruction.
    always_comb begin
        is_mark   = cmt_valid && (cmt_kind_e'(cmt_kind) == CK_MARK);
        is_enter  = is_mark && (|cmt_operand);
        is_exit   = is_mark && !(|cmt_operand);
        is_atomic = cmt_valid && (cmt_kind_e'(cmt_kind) == CK_ATOMIC);
    end

    // Mode flag, handler address and post-exit window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relaxed <= 1'b0;
            rpc     <= '0;
            grace   <= '0;
        end else if (flush) begin
            relaxed <= 1'b0;
            grace   <= '0;
        end else if (is_enter && !relaxed) begin
            relaxed <= 1'b1;
            rpc     <= cmt_operand;
            grace   <= '0;
        end else if (is_exit && relaxed) begin
            relaxed <= 1'b0;
            grace   <= GRACE_INIT;
        end else if (grace != '0) begin
            grace   <= grace - 1'b1;
        end
    end

    // Illegal-operation pulse: nested open or atomic inside a region.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_err <= 1'b0;
        else        illegal_err <= relaxed && (is_enter || is_atomic);
    end

    // A fault now is attributable to the region.
    assign covered = relaxed || (grace != '0);
endmodule

// File: rtl/rcv_fault_route.sv
// Fault router: turns a detector report into a redirect when covered by a
// region, or into an unrecoverable-fault pulse otherwise. Registered outputs.
module rcv_fault_route #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_valid,
    input  logic            covered,
    input  logic [PC_W-1:0] rpc,
    output logic            fire,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic            unrec_fault
);
    // Redirect decision this cycle.
    assign fire = fault_valid && covered;

    // Register the redirect request, its target and the unrecoverable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            unrec_fault    <= 1'b0;
        end else begin
            redirect_valid <= fire;
            redirect_pc    <= fire ? rpc : '0;
            unrec_fault    <= fault_valid && !covered;
        end
    end
endmodule

// File: rtl/rcv_exc_gate.sv
// Exception gate: holds a trap raised inside a region for DET_LAT cycles so
// a late fault can still redirect; also holds through the redirect cycle.
// Assumes exc_req stays high until the trap is taken or the pipe flushes.
module rcv_exc_gate #(
    parameter int DET_LAT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_req,
    input  logic covered,
    input  logic fire,
    input  logic redirect_valid,
    output logic exc_hold
);
    localparam int CW = $clog2(DET_LAT + 1);
    localparam logic [CW-1:0] WAIT_INIT = CW'(DET_LAT - 1);

    logic          armed;
    logic [CW-1:0] cnt;

    // Arm on the first covered request cycle and count the remaining wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !exc_req || fire) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!armed && covered) begin
            armed <= 1'b1;
            cnt   <= WAIT_INIT;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    // Hold while detection for the trapping instruction is pending.
    assign exc_hold = exc_req && ((!armed && covered) || (cnt != '0) || redirect_valid);
endmodule

// File: rtl/rcv_region_ctrl.sv
// Top: recoverable-region fault redirect controller. Ties the region
// tracker, fault router and exception gate together.
// Assumes DET_LAT >= 1 is the detector's worst-case report latency.
module rcv_region_ctrl #(
    parameter int PC_W    = 32,
    parameter int DET_LAT = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmt_valid,
    input  logic [1:0]      cmt_kind,
    input  logic [PC_W-1:0] cmt_operand,
    input  logic            fault_valid,
    input  logic            exc_req,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic            exc_hold,
    output logic            illegal_err,
    output logic            unrec_fault,
    output logic            relaxed_mode
);
    logic            covered;
    logic            fire;
    logic [PC_W-1:0] rpc;

    rcv_region_track #(.PC_W(PC_W), .DET_LAT(DET_LAT)) i_track (
        .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_kind(cmt_kind),
        .cmt_operand(cmt_operand), .flush(fire), .relaxed(relaxed_mode),
        .rpc(rpc), .covered(covered), .illegal_err(illegal_err)
    );

    rcv_fault_route #(.PC_W(PC_W)) i_route (
        .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .covered(covered),
        .rpc(rpc), .fire(fire), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .unrec_fault(unrec_fault)
    );

    rcv_exc_gate #(.DET_LAT(DET_LAT)) i_gate (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .covered(covered),
        .fire(fire), .redirect_valid(redirect_valid), .exc_hold(exc_hold)
    );
endmodule

// File: rtl/rcv_region_ctrl_chk.sv
// Checker for rcv_region_ctrl, attached by bind. Port-level properties only.
module rcv_region_ctrl_chk #(
    parameter int PC_W    = 32,
    parameter int DET_LAT = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmt_valid,
    input logic [1:0]      cmt_kind,
    input logic [PC_W-1:0] cmt_operand,
    input logic            fault_valid,
    input logic            exc_req,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc,
    input logic            exc_hold,
    input logic            illegal_err,
    input logic            unrec_fault,
    input logic            relaxed_mode
);
    localparam int HW = $clog2(DET_LAT + 2) + 1;
    logic [HW-1:0] hold_run;

    // Length of the current hold stretch, not counting redirect cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !exc_hold || redirect_valid) hold_run <= '0;
        else                                       hold_run <= hold_run + 1'b1;
    end

    AST_REDIRECT_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(fault_valid)); // R3
    AST_REDIRECT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!relaxed_mode && redirect_pc != '0)); // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_valid && unrec_fault)); // R5
    AST_UNREC_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        unrec_fault |-> $past(fault_valid) && !$past(relaxed_mode)); // R5
    AST_HOLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_hold |-> exc_req); // R7
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hold_run) <= DET_LAT); // R7
    AST_ATOMIC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (relaxed_mode && cmt_valid && cmt_kind == 2'b10) |=> illegal_err); // R9
    AST_NEST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (relaxed_mode && cmt_valid && cmt_kind == 2'b01 && cmt_operand != '0) |=> illegal_err); // R10
    AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!relaxed_mode && !(cmt_valid && cmt_kind == 2'b01 && cmt_operand != '0)) |=> !relaxed_mode); // R1
endmodule

bind rcv_region_ctrl rcv_region_ctrl_chk #(.PC_W(PC_W), .DET_LAT(DET_LAT)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_kind(cmt_kind),
    .cmt_operand(cmt_operand), .fault_valid(fault_valid), .exc_req(exc_req),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .exc_hold(exc_hold),
    .illegal_err(illegal_err), .unrec_fault(unrec_fault), .relaxed_mode(relaxed_mode)
);

// File: tb/test_rcv_region_ctrl.sv
`timescale 1ns/1ps
module test_rcv_region_ctrl;
    localparam int PCW = 16;
    localparam int LAT = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmt_valid = 1'b0;
    logic [1:0]     cmt_kind = 2'b00;
    logic [PCW-1:0] cmt_operand = '0;
    logic           fault_valid = 1'b0;
    logic           exc_req = 1'b0;
    logic           redirect_valid, exc_hold, illegal_err, unrec_fault, relaxed_mode;
    logic [PCW-1:0] redirect_pc;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rcv_region_ctrl #(.PC_W(PCW), .DET_LAT(LAT)) i_rcv_region_ctrl (
        .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_kind(cmt_kind),
        .cmt_operand(cmt_operand), .fault_valid(fault_valid), .exc_req(exc_req),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .exc_hold(exc_hold),
        .illegal_err(illegal_err), .unrec_fault(unrec_fault), .relaxed_mode(relaxed_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Present one commit for one cycle; return with registered outputs updated.
    task automatic commit(input logic [1:0] kind, input logic [PCW-1:0] op);
        cmt_valid = 1'b1; cmt_kind = kind; cmt_operand = op;
        tick();
        cmt_valid = 1'b0; cmt_kind = 2'b00; cmt_operand = '0;
    endtask

    task automatic fault();
        fault_valid = 1'b1;
        tick();
        fault_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R11 reset state
        chk("R11 relaxed_mode", relaxed_mode, 0);
        chk("R11 redirect_valid", redirect_valid, 0);
        chk("R11 redirect_pc", redirect_pc, 0);
        chk("R11 exc_hold", exc_hold, 0);
        chk("R11 illegal_err", illegal_err, 0);
        chk("R11 unrec_fault", unrec_fault, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 open, R3 redirect, R6 cleared and next fault unrecoverable
        commit(2'b01, 16'h1234);
        chk("R1 mode set", relaxed_mode, 1);
        fault();
        chk("R3 redirect_valid", redirect_valid, 1);
        chk("R3 redirect_pc", redirect_pc, 16'h1234);
        chk("R6 mode cleared", relaxed_mode, 0);
        tick();
        chk("R3 single pulse", redirect_valid, 0);
        chk("R3 pc zero after", redirect_pc, 0);
        fault();
        chk("R6 unrec after redirect", unrec_fault, 1);
        chk("R5 no redirect", redirect_valid, 0);
        tick();
        chk("R5 unrec pulse", unrec_fault, 0);

        // R2/R4 sweep of fault offset relative to the closing marker
        for (int k = 0; k <= LAT + 2; k++) begin
            logic [PCW-1:0] pc;
            bit exp_rd;
            pc = PCW'(16'h0100 + k);
            exp_rd = (k <= LAT);
            commit(2'b01, pc);
            cmt_valid = 1'b1; cmt_kind = 2'b01; cmt_operand = '0;
            if (k == 0) fault_valid = 1'b1;
            tick();
            cmt_valid = 1'b0; cmt_kind = 2'b00; fault_valid = 1'b0;
            chk("R2 mode cleared by close", relaxed_mode, 0);
            if (k > 0) begin
                idle(k - 1);
                fault();
            end
            chk("R4 redirect in window", redirect_valid, 32'(exp_rd));
            chk("R4 redirect target", redirect_pc, exp_rd ? 32'(pc) : 0);
            chk("R5 unrec past window", unrec_fault, 32'(!exp_rd));
            idle(LAT + 2);
        end

        // R12 close outside region
        commit(2'b01, '0);
        fault();
        chk("R12 close ignored", unrec_fault, 1);
        chk("R12 no redirect", redirect_valid, 0);
        idle(2);

        // R9 atomic outside and inside
        commit(2'b10, '0);
        chk("R9 atomic outside ok", illegal_err, 0);
        commit(2'b01, 16'h0A00);
        commit(2'b10, '0);
        chk("R9 atomic inside error", illegal_err, 1);
        chk("R9 mode kept", relaxed_mode, 1);
        tick();
        chk("R9 error pulse", illegal_err, 0);

        // R10 nested open keeps handler
        commit(2'b01, 16'h2222);
        chk("R10 nested error", illegal_err, 1);
        fault();
        chk("R10 handler unchanged", redirect_pc, 16'h0A00);
        idle(2);

        // R7 hold length sweep inside a region
        commit(2'b01, 16'h0B00);
        exc_req = 1'b1;
        #1;
        for (int i = 0; i <= LAT + 1; i++) begin
            chk("R7 hold length", exc_hold, 32'(i < LAT));
            tick();
        end
        exc_req = 1'b0;
        commit(2'b01, '0);
        idle(LAT + 2);
        exc_req = 1'b1;
        #1;
        chk("R7 no hold outside", exc_hold, 0);
        tick();
        chk("R7 no hold outside later", exc_hold, 0);
        exc_req = 1'b0;
        idle(2);

        // R8 fault during hold at every offset
        for (int f = 0; f < LAT; f++) begin
            commit(2'b01, PCW'(16'h0C00 + f));
            exc_req = 1'b1;
            #1;
            for (int i = 0; i < f; i++) tick();
            fault_valid = 1'b1;
            #1;
            chk("R8 held at fault", exc_hold, 1);
            tick();
            fault_valid = 1'b0;
            #1;
            chk("R8 redirect wins", redirect_valid, 1);
            chk("R8 target", redirect_pc, 32'(16'h0C00 + f));
            chk("R8 held through redirect", exc_hold, 1);
            tick();
            chk("R8 released after", exc_hold, 0);
            exc_req = 1'b0;
            idle(2);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule